// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block takes a set of maskable peripheral interrupt lines and a few special non-maskable sources, and picks the single request each consumer should see. Every maskable line has a 3-bit priority level and a destination bit. The destination is either the main CPU or a coprocessor. Requests routed to the CPU must also pass the CPU's interrupt mask bit. Their level must be strictly above the CPU's current processing level, so a running handler can only be pre-empted by a more urgent one.

When the CPU performs a vector fetch, the block captures a 16-bit vector address. For maskable and most special sources, the upper byte comes from a programmable base register and the lower byte is a fixed slot offset. The three reset sources use fixed addresses at the top of memory. If nothing is valid at fetch time, the spurious vector is returned. The coprocessor is not given an address. It receives a request flag and a channel index. Two wake-up outputs let a qualifying request bring the CPU, or only the coprocessor, out of a low-power mode. A plain write port and a combinational read port give access to the base register and the per-line configuration.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Register address 0 holds the 8-bit vector base and resets to 0xFF. It reads back what was written, and it forms the upper byte of every non-reset vector.
- R2: Maskable line k has vector {base, 0x12 + 2*k}. The highest-numbered line (NUM_REQ-1) is the external IRQ pin request.
- R3: Register address k+1 configures line k. Bits [2:0] hold the level (reset value 1) and bit 7 is the destination (1 = coprocessor, reset value 0), and the register reads back as {dest, 0000, level}. A level of 0 disables the line. A CPU-routed line is presented only if its level is strictly greater than cpu_ipl and cpu_ibit is 0.
- R4: Among eligible lines, the highest level wins. On a tie, the higher line index, which has the higher vector address, wins.
- R5: A line with destination 1 is never presented to the CPU. The coprocessor side raises cop_req, and cop_chan carries the index of the winning line, chosen by the same level-then-index rule.
- R6: The destination bit written for the IRQ pin line is ignored. That line reads back with bit 7 clear and is always handled by the CPU.
- R7: Special sources take precedence over every maskable line, in this order: reset source 0 (vector 0xFFFE), reset source 1 (0xFFFC), reset source 2 (0xFFFA), trap ({base,0xF8}), software interrupt ({base,0xF6}), and XIRQ ({base,0xF4}). XIRQ counts only when cpu_xbit is 0.
- R8: If no request is valid in the cycle of the vector fetch, the vector is {base, 0x10}. This includes a winner that dropped after cpu_int_req was raised.
- R9: cpu_wake rises for any of the following: an enabled CPU-routed line while cpu_ibit is 0, any XIRQ assertion regardless of cpu_xbit, a trap, a software interrupt or a reset source. cop_wake rises only for an enabled coprocessor-routed line.
- R10: All outputs are registered. cpu_int_req, cop_req, cop_chan and both wake outputs reflect the inputs one clock later. cpu_vector and cpu_vec_valid update the clock after vec_fetch is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address (0 = base, k+1 = line k) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_req | input | NUM_REQ | Maskable request lines |
| xirq_req | input | 1 | Non-maskable-by-I XIRQ request |
| swi_req | input | 1 | Software interrupt request |
| trap_req | input | 1 | Unimplemented-opcode trap request |
| rst_src | input | 3 | System reset sources, bit 0 most urgent |
| cpu_ipl | input | 3 | Current CPU processing level |
| cpu_ibit | input | 1 | CPU maskable-interrupt mask |
| cpu_xbit | input | 1 | CPU XIRQ mask |
| vec_fetch | input | 1 | CPU vector fetch strobe |
| cpu_int_req | output | 1 | A request is pending for the CPU |
| cpu_vec_valid | output | 1 | cpu_vector holds a freshly fetched vector |
| cpu_vector | output | 16 | Captured vector address |
| cop_req | output | 1 | A request is pending for the coprocessor |
| cop_chan | output | IW | Winning coprocessor line index |
| cpu_wake | output | 1 | Wake request for the CPU |
| cop_wake | output | 1 | Wake request for the coprocessor |

## Verification
The hardest situation to reach is a fetch that arrives after cpu_int_req has been raised but after its cause has gone, because that needs the request to vanish in the one-cycle gap. The stimulus first lets a CPU-routed line raise cpu_int_req. It then drops the line on the same falling edge that raises vec_fetch, so the sampling clock sees a fetch with nothing valid and the spurious vector is expected. Nesting is reached by stepping cpu_ipl across the configured levels and by toggling cpu_ibit while the same lines stay asserted.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef struct packed {
    logic       route_cop;
    logic [2:0] level;
  } irqv_cfg_t;

  localparam logic [7:0]  OFS_SPUR  = 8'h10;
  localparam logic [7:0]  OFS_FIRST = 8'h12;
  localparam logic [7:0]  OFS_XIRQ  = 8'hF4;
  localparam logic [7:0]  OFS_SWI   = 8'hF6;
  localparam logic [7:0]  OFS_TRAP  = 8'hF8;
  localparam logic [15:0] VEC_RST0  = 16'hFFFE;
  localparam logic [15:0] VEC_RST1  = 16'hFFFC;
  localparam logic [15:0] VEC_RST2  = 16'hFFFA;
  localparam logic [7:0]  BASE_RST  = 8'hFF;

  function automatic logic [7:0] slot_ofs(int unsigned idx);
    return 8'(OFS_FIRST + 8'(2 * idx));
  endfunction

endpackage

// File: rtl/irqv_cfg_regs.sv
module irqv_cfg_regs
  import irqv_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int AW      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [7:0]                  wdata,
  output logic [7:0]                  rdata,
  output logic [7:0]                  base,
  output irqv_cfg_t [NUM_REQ-1:0]     cfg
);

  localparam int IRQ_PIN = NUM_REQ - 1;

  logic [7:0] base_q, base_d;
  logic       base_hit;
  logic       unused_wbits;

  assign unused_wbits = ^wdata[6:3];
  assign base_hit     = we && (addr == '0);

  always_comb begin
    base_d = base_q;
    if (base_hit) base_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= BASE_RST;
    else if (base_hit) base_q <= base_d;
  end

  assign base = base_q;

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_ent
    irqv_cfg_t ent_q, ent_d;
    logic      hit;

    assign hit = we && (addr == AW'(k + 1));

    always_comb begin
      ent_d = ent_q;
      if (hit) begin
        ent_d.level     = wdata[2:0];
        ent_d.route_cop = (k == IRQ_PIN) ? 1'b0 : wdata[7];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q <= '{route_cop: 1'b0, level: 3'd1};
      else if (hit) ent_q <= ent_d;
    end

    assign cfg[k] = ent_q;
  end

  always_comb begin
    rdata = 8'h00;
    if (addr == '0) rdata = base_q;
    for (int k = 0; k < NUM_REQ; k++) begin
      if (addr == AW'(k + 1)) rdata = {cfg[k].route_cop, 4'b0000, cfg[k].level};
    end
  end

  AST_IRQ_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    we && (addr == AW'(NUM_REQ)) |=> !cfg[IRQ_PIN].route_cop); // R6

endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick
  import irqv_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int IW      = 3
) (
  input  logic [NUM_REQ-1:0]      elig,
  input  irqv_cfg_t [NUM_REQ-1:0] cfg,
  output logic                    win_valid,
  output logic [IW-1:0]           win_idx,
  output logic [2:0]              win_level
);

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_level = 3'd0;
    for (int k = 0; k < NUM_REQ; k++) begin
      if (elig[k] && (cfg[k].level >= win_level)) begin
        win_valid = 1'b1;
        win_idx   = IW'(k);
        win_level = cfg[k].level;
      end
    end
  end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqv_pkg::*;
#(
  parameter  int NUM_REQ = 8,
  localparam int IW      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
  localparam int AW      = $clog2(NUM_REQ + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [NUM_REQ-1:0] irq_req,
  input  logic               xirq_req,
  input  logic               swi_req,
  input  logic               trap_req,
  input  logic [2:0]         rst_src,
  input  logic [2:0]         cpu_ipl,
  input  logic               cpu_ibit,
  input  logic               cpu_xbit,
  input  logic               vec_fetch,
  output logic               cpu_int_req,
  output logic               cpu_vec_valid,
  output logic [15:0]        cpu_vector,
  output logic               cop_req,
  output logic [IW-1:0]      cop_chan,
  output logic               cpu_wake,
  output logic               cop_wake
);

  logic [7:0]                base;
  irqv_cfg_t [NUM_REQ-1:0]   cfg;
  logic [NUM_REQ-1:0]        cpu_elig, cop_elig, cpu_pend;
  logic                      cpu_win_valid, cop_win_valid;
  logic [IW-1:0]             cpu_win_idx, cop_win_idx;
  logic [2:0]                cpu_win_level, cop_win_level;
  logic                      cur_valid;
  logic [15:0]               cur_vec;

  irqv_cfg_regs #(.NUM_REQ(NUM_REQ), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .base(base), .cfg(cfg)
  );

  always_comb begin
    for (int k = 0; k < NUM_REQ; k++) begin
      cpu_pend[k] = irq_req[k] && (cfg[k].level != 3'd0) && !cfg[k].route_cop;
      cpu_elig[k] = cpu_pend[k] && (cfg[k].level > cpu_ipl) && !cpu_ibit;
      cop_elig[k] = irq_req[k] && (cfg[k].level != 3'd0) && cfg[k].route_cop;
    end
  end

  irqv_prio_pick #(.NUM_REQ(NUM_REQ), .IW(IW)) u_cpu_pick (
    .elig(cpu_elig), .cfg(cfg), .win_valid(cpu_win_valid),
    .win_idx(cpu_win_idx), .win_level(cpu_win_level)
  );

  irqv_prio_pick #(.NUM_REQ(NUM_REQ), .IW(IW)) u_cop_pick (
    .elig(cop_elig), .cfg(cfg), .win_valid(cop_win_valid),
    .win_idx(cop_win_idx), .win_level(cop_win_level)
  );

  always_comb begin
    cur_valid = 1'b1;
    if (rst_src[0])                  cur_vec = VEC_RST0;
    else if (rst_src[1])             cur_vec = VEC_RST1;
    else if (rst_src[2])             cur_vec = VEC_RST2;
    else if (trap_req)               cur_vec = {base, OFS_TRAP};
    else if (swi_req)                cur_vec = {base, OFS_SWI};
    else if (xirq_req && !cpu_xbit)  cur_vec = {base, OFS_XIRQ};
    else if (cpu_win_valid)          cur_vec = {base, slot_ofs(int'(cpu_win_idx))};
    else begin
      cur_valid = 1'b0;
      cur_vec   = {base, OFS_SPUR};
    end
  end

  logic          int_req_d, vv_d, cop_req_d, cpu_wake_d, cop_wake_d;
  logic [15:0]   vec_d;
  logic [IW-1:0] chan_d;

  always_comb begin
    int_req_d  = cur_valid;
    vv_d       = vec_fetch;
    vec_d      = vec_fetch ? cur_vec : cpu_vector;
    cop_req_d  = cop_win_valid;
    chan_d     = cop_win_valid ? cop_win_idx : cop_chan;
    cpu_wake_d = ((|cpu_pend) && !cpu_ibit) || xirq_req || swi_req || trap_req || (|rst_src);
    cop_wake_d = |cop_elig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_int_req   <= 1'b0;
      cpu_vec_valid <= 1'b0;
      cpu_vector    <= 16'h0000;
      cop_req       <= 1'b0;
      cop_chan      <= '0;
      cpu_wake      <= 1'b0;
      cop_wake      <= 1'b0;
    end else begin
      cpu_int_req   <= int_req_d;
      cpu_vec_valid <= vv_d;
      if (vec_fetch)     cpu_vector <= vec_d;
      cop_req       <= cop_req_d;
      if (cop_win_valid) cop_chan <= chan_d;
      cpu_wake      <= cpu_wake_d;
      cop_wake      <= cop_wake_d;
    end
  end

  AST_VEC_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |=> cpu_vec_valid); // R10
  AST_SPURIOUS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch && !cur_valid |=> cpu_vector == {$past(base), 8'h10}); // R8
  AST_XIRQ_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    xirq_req |=> cpu_wake); // R9
  AST_NEST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_win_valid |-> (cpu_win_level > cpu_ipl) && !cpu_ibit); // R3
  AST_COP_NOT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cop_win_valid |-> (cop_win_idx != IW'(NUM_REQ - 1)) && (cop_win_level != 3'd0)); // R6
  AST_RST_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    rst_src[0] && vec_fetch |=> cpu_vector == 16'hFFFE); // R7

endmodule

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;

  localparam int N  = 8;
  localparam int IW = 3;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic [N-1:0]  irq_req;
  logic          xirq_req, swi_req, trap_req;
  logic [2:0]    rst_src, cpu_ipl;
  logic          cpu_ibit, cpu_xbit, vec_fetch;
  logic          cpu_int_req, cpu_vec_valid, cop_req, cpu_wake, cop_wake;
  logic [15:0]   cpu_vector;
  logic [IW-1:0] cop_chan;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_vec_ctrl #(.NUM_REQ(N)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .xirq_req(xirq_req), .swi_req(swi_req), .trap_req(trap_req),
    .rst_src(rst_src), .cpu_ipl(cpu_ipl), .cpu_ibit(cpu_ibit),
    .cpu_xbit(cpu_xbit), .vec_fetch(vec_fetch), .cpu_int_req(cpu_int_req),
    .cpu_vec_valid(cpu_vec_valid), .cpu_vector(cpu_vector), .cop_req(cop_req),
    .cop_chan(cop_chan), .cpu_wake(cpu_wake), .cop_wake(cop_wake)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fetch(string tag, logic [15:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    vec_fetch = 1'b1;
    @(negedge clk);
    vec_fetch = 1'b0;
  endtask

  // monitor: pops the scoreboard whenever a vector is presented
  always @(negedge clk) begin
    if (rst_n && cpu_vec_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected vector", 32'(cpu_vector), 32'hxxxx);
      else chk(tag_q.pop_front(), 32'(cpu_vector), 32'(exp_q.pop_front()));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_req = '0; xirq_req = 1'b0; swi_req = 1'b0; trap_req = 1'b0;
    rst_src = '0; cpu_ipl = '0; cpu_ibit = 1'b0; cpu_xbit = 1'b0; vec_fetch = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // reset state
    reg_addr = 0; #1 chk("R1 base reset", 32'(reg_rdata), 32'hFF);
    reg_addr = 3; #1 chk("R3 cfg reset", 32'(reg_rdata), 32'h01);
    chk("R10 int_req reset", 32'(cpu_int_req), 0);
    chk("R5 cop_req reset", 32'(cop_req), 0);
    chk("R9 wake reset", 32'({cpu_wake, cop_wake}), 0);

    wr(0, 8'h40);
    reg_addr = 0; #1 chk("R1 base readback", 32'(reg_rdata), 32'h40);

    // line 2 at default level 1
    tick(1);
    irq_req = 8'h04;
    #1 chk("R10 no same-cycle change", 32'(cpu_int_req), 0);
    tick(1);
    chk("R3 request presented", 32'(cpu_int_req), 1);
    chk("R9 cpu wake", 32'(cpu_wake), 1);
    fetch("R2 line2 vector", 16'h4016);

    irq_req = 8'h24; tick(1);
    fetch("R4 tie higher index", 16'h401C);

    wr(6, 8'h03); wr(3, 8'h06); tick(1);
    fetch("R4 higher level wins", 16'h4016);

    cpu_ipl = 3'd6; tick(1);
    chk("R3 level not above ipl", 32'(cpu_int_req), 0);
    cpu_ipl = 3'd2; tick(1);
    fetch("R3 nesting above ipl", 16'h4016);
    cpu_ibit = 1'b1; tick(1);
    chk("R3 ibit masks", 32'(cpu_int_req), 0);
    chk("R9 no wake under ibit", 32'(cpu_wake), 0);
    cpu_ibit = 1'b0; cpu_ipl = 3'd0;

    irq_req = 8'h04; wr(3, 8'h00); tick(1);
    chk("R3 level0 disabled", 32'(cpu_int_req), 0);
    reg_addr = 3; #1 chk("R3 cfg readback", 32'(reg_rdata), 32'h00);

    irq_req = 8'h20; wr(6, 8'h83); tick(1);
    chk("R5 cop_req", 32'(cop_req), 1);
    chk("R5 cop_chan", 32'(cop_chan), 5);
    chk("R9 cop_wake", 32'(cop_wake), 1);
    chk("R5 not to cpu", 32'(cpu_int_req), 0);
    chk("R9 no cpu wake for cop line", 32'(cpu_wake), 0);

    wr(8, 8'h84);
    reg_addr = 8; #1 chk("R6 irq pin dest ignored", 32'(reg_rdata), 32'h04);
    irq_req = 8'h80; tick(1);
    chk("R6 irq pin not to cop", 32'(cop_req), 0);
    chk("R6 irq pin to cpu", 32'(cpu_int_req), 1);
    fetch("R2 irq pin vector", 16'h4020);

    irq_req = 8'h08; tick(1);
    chk("R8 request raised", 32'(cpu_int_req), 1);
    irq_req = 8'h00;
    fetch("R8 spurious vector", 16'h4010);

    xirq_req = 1'b1; irq_req = 8'h80; tick(1);
    fetch("R7 xirq over maskable", 16'h40F4);
    irq_req = 8'h00; cpu_xbit = 1'b1; tick(1);
    chk("R7 xirq masked by xbit", 32'(cpu_int_req), 0);
    chk("R9 xirq wakes despite xbit", 32'(cpu_wake), 1);
    swi_req = 1'b1; tick(1);
    fetch("R7 swi vector", 16'h40F6);
    trap_req = 1'b1; tick(1);
    fetch("R7 trap over swi", 16'h40F8);
    rst_src = 3'b110; tick(1);
    fetch("R7 reset1 over reset2", 16'hFFFC);
    rst_src = 3'b111; tick(1);
    fetch("R7 reset0 first", 16'hFFFE);
    rst_src = 3'b100; tick(1);
    fetch("R7 reset2 vector", 16'hFFFA);
    rst_src = '0; trap_req = 1'b0; swi_req = 1'b0; xirq_req = 1'b0; cpu_xbit = 1'b0;

    tick(3);
    chk("R10 all vectors seen", 32'(exp_q.size()), 0);
    finish_run();
  end

endmodule